// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two channels of an incremental encoder into a position count. The count runs between zero and a programmable ceiling. A two-bit source field picks how the channels become count pulses: full quadrature decoding, pulse plus direction, up-only counting or down-only counting. In the two single-direction modes, a rate bit chooses whether one or both edges of channel A count.

Software reaches the block through a simple synchronous register port. A write strobe takes effect on the clock edge where it is sampled. A read strobe loads `reg_rdata` on that same edge, so the data is valid from the following cycle until the next read. The port carries no handshake and never stalls. Wrapping past the ceiling or below zero sets a sticky flag. Each flag has its own enable. The interrupt output follows a global flag. That global flag is set whenever an enabled source flag is set, and every flag is cleared by writing a one to the clear register.

Both encoder inputs pass through a two-flop synchronizer and then an edge-detect register. An input change therefore reaches the position register on the third rising clock edge after it is first sampled.

Top module: `qep_pos_counter`

## Requirements
- R1: After reset the position reads 0, the maximum reads 0xFFFFFFFF, the decode, control, enable and flag registers read 0, and `irq` is low.
- R2: With source 0 (quadrature), every change of a single input counts once. The order {A,B} = 00→01→11→10→00 counts up and the reverse order counts down, so one full cycle gives four counts.
- R3: In quadrature mode, a change of both inputs in the same sample (an illegal transition) leaves the position unchanged.
- R4: With source 1 (pulse plus direction), only rising edges of A count. They count up while B is high and down while B is low.
- R5: With source 2 the count goes up and with source 3 it goes down, on A only, with B ignored. Rate bit (decode register bit 2) clear counts rising edges of A only; set counts both edges.
- R6: While the enable bit (control register bit 0) is clear, the position holds its value whatever the inputs do.
- R7: A write to the position register takes effect only if the written value is not greater than the maximum register. Otherwise the position is unchanged.
- R8: Counting up from a value at or above the maximum wraps to 0 and sets the overflow flag (bit 6). Counting down from 0 wraps to the maximum and sets the underflow flag (bit 5).
- R9: The global flag (flag register bit 0) is set when a source flag is set while its enable bit (the same position in the enable register) is set. `irq` is high exactly while the global flag is set. A source whose enable is clear sets only its own flag.
- R10: Flags are sticky. Writing a one to a bit of the clear register clears the matching flag, and zero bits leave flags unchanged.
- R11: Register map: 0x00 position and 0x04 maximum are 32 bits wide. The 16-bit registers are 0x10 decode (bits 1:0 source, bit 2 rate), 0x12 control (bit 0 enable), 0x14 interrupt enable, 0x16 flags (read only) and 0x18 clear (write only, reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, loaded on the edge that samples `reg_rd` |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| irq | output | 1 | Level interrupt, high while the global flag is set |

## Verification
Several properties are checked on every cycle:
- the position holds while counting is disabled and no write occurs;
- a write above the maximum leaves the position unchanged;
- a wrap lands on 0 or on the maximum;
- flags stay set until cleared;
- an enabled wrap raises `irq`;
- each quadrature count comes from a single-input change.

Only the directed scenarios can show the behaviour that depends on sequences of stimuli. This covers the net count for each source mode and rate setting, that B is ignored in the single-direction modes, that illegal double transitions are rejected, the register map and its reset values, and the masked-source case where a flag is set without an interrupt.

// File: rtl/qep_pkg.sv
package qep_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_PDIR = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_mode_e;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADR_POS = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MAX = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_DEC = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_CTL = 8'h12;
  localparam logic [ADDR_W-1:0] ADR_IEN = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_FLG = 8'h16;
  localparam logic [ADDR_W-1:0] ADR_CLR = 8'h18;

  localparam int FLG_GLB = 0;
  localparam int FLG_UNF = 5;
  localparam int FLG_OVF = 6;
  localparam int HALF_W  = 16;
endpackage

// File: rtl/qep_sync.sv
module qep_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= async_in[i];
        st2 <= st1;
      end
    end
    assign sync_out[i] = st2;
  end
endmodule

// File: rtl/qep_pulse_gen.sv
module qep_pulse_gen
  import qep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a_in,
  input  logic      b_in,
  input  src_mode_e mode,
  input  logic      both_edges,
  output logic      pulse,
  output logic      up
);
  logic a_prev, b_prev;
  logic [1:0] ph_now, ph_old, ph_step;
  logic a_rise, a_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a_in;
      b_prev <= b_in;
    end
  end

  // Gray state to phase index: 00->0, 01->1, 11->2, 10->3
  assign ph_now  = {a_in, a_in ^ b_in};
  assign ph_old  = {a_prev, a_prev ^ b_prev};
  assign ph_step = ph_now - ph_old;
  assign a_rise  = a_in & ~a_prev;
  assign a_fall  = ~a_in & a_prev;

  always_comb begin
    pulse = 1'b0;
    up    = 1'b0;
    unique case (mode)
      SRC_QUAD: begin
        pulse = (ph_step == 2'd1) || (ph_step == 2'd3);
        up    = (ph_step == 2'd1);
      end
      SRC_PDIR: begin
        pulse = a_rise;
        up    = b_in;
      end
      SRC_UP: begin
        pulse = a_rise | (both_edges & a_fall);
        up    = 1'b1;
      end
      SRC_DOWN: begin
        pulse = a_rise | (both_edges & a_fall);
        up    = 1'b0;
      end
      default: ;
    endcase
  end

  // R2
  quad_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && mode == SRC_QUAD) |-> $countones({a_in ^ a_prev, b_in ^ b_prev}) == 1);
endmodule

// File: rtl/qep_pos_core.sv
module qep_pos_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             pulse,
  input  logic             up,
  input  logic             pos_wr,
  input  logic [CNT_W-1:0] pos_wdata,
  input  logic [CNT_W-1:0] max_pos,
  output logic [CNT_W-1:0] pos,
  output logic             ovf_evt,
  output logic             unf_evt
);
  logic step;
  logic wr_ok;

  assign step    = cnt_en & pulse;
  assign wr_ok   = pos_wr && (pos_wdata <= max_pos);
  assign ovf_evt = step && up && (pos >= max_pos) && !pos_wr;
  assign unf_evt = step && !up && (pos == '0) && !pos_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (pos_wr) begin
      if (wr_ok) pos <= pos_wdata;
    end else if (step) begin
      if (up) pos <= (pos >= max_pos) ? '0 : pos + 1'b1;
      else    pos <= (pos == '0) ? max_pos : pos - 1'b1;
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !pos_wr) |=> $stable(pos));
  // R7
  reject_big_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_wr && pos_wdata > max_pos) |=> $stable(pos));
  // R8
  ovf_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> pos == '0);
  // R8
  unf_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> pos == $past(max_pos));
endmodule

// File: rtl/qep_regs.sv
module qep_regs
  import qep_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [CNT_W-1:0]  pos,
  input  logic              ovf_evt,
  input  logic              unf_evt,
  output logic [CNT_W-1:0]  max_pos,
  output logic              pos_wr,
  output src_mode_e         mode,
  output logic              both_edges,
  output logic              cnt_en,
  output logic              irq
);
  logic ien_ovf, ien_unf;
  logic flg_ovf, flg_unf, flg_glb;
  logic clr_wr;
  logic [HALF_W-1:0] dec_rd, ctl_rd, ien_rd, flg_rd;

  assign pos_wr = reg_wr && (reg_addr == ADR_POS);
  assign clr_wr = reg_wr && (reg_addr == ADR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_pos    <= '1;
      mode       <= SRC_QUAD;
      both_edges <= 1'b0;
      cnt_en     <= 1'b0;
      ien_ovf    <= 1'b0;
      ien_unf    <= 1'b0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        ADR_MAX: max_pos <= reg_wdata;
        ADR_DEC: begin
          mode       <= src_mode_e'(reg_wdata[1:0]);
          both_edges <= reg_wdata[2];
        end
        ADR_CTL: cnt_en <= reg_wdata[0];
        ADR_IEN: begin
          ien_ovf <= reg_wdata[FLG_OVF];
          ien_unf <= reg_wdata[FLG_UNF];
        end
        default: ;
      endcase
    end
  end

  // Flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_ovf <= 1'b0;
      flg_unf <= 1'b0;
      flg_glb <= 1'b0;
    end else begin
      if (ovf_evt) flg_ovf <= 1'b1;
      else if (clr_wr && reg_wdata[FLG_OVF]) flg_ovf <= 1'b0;
      if (unf_evt) flg_unf <= 1'b1;
      else if (clr_wr && reg_wdata[FLG_UNF]) flg_unf <= 1'b0;
      if ((ovf_evt && ien_ovf) || (unf_evt && ien_unf)) flg_glb <= 1'b1;
      else if (clr_wr && reg_wdata[FLG_GLB]) flg_glb <= 1'b0;
    end
  end

  assign irq = flg_glb;

  always_comb begin
    dec_rd = '0;
    dec_rd[1:0] = mode;
    dec_rd[2]   = both_edges;
    ctl_rd = '0;
    ctl_rd[0] = cnt_en;
    ien_rd = '0;
    ien_rd[FLG_OVF] = ien_ovf;
    ien_rd[FLG_UNF] = ien_unf;
    flg_rd = '0;
    flg_rd[FLG_OVF] = flg_ovf;
    flg_rd[FLG_UNF] = flg_unf;
    flg_rd[FLG_GLB] = flg_glb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADR_POS: reg_rdata <= pos;
        ADR_MAX: reg_rdata <= max_pos;
        ADR_DEC: reg_rdata <= CNT_W'(dec_rd);
        ADR_CTL: reg_rdata <= CNT_W'(ctl_rd);
        ADR_IEN: reg_rdata <= CNT_W'(ien_rd);
        ADR_FLG: reg_rdata <= CNT_W'(flg_rd);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_ovf && !(clr_wr && reg_wdata[FLG_OVF])) |=> flg_ovf);
  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_unf && !(clr_wr && reg_wdata[FLG_UNF])) |=> flg_unf);
  // R9
  enabled_ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ien_ovf) |=> irq);
  // R9
  enabled_unf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && ien_unf) |=> irq);
endmodule

// File: rtl/qep_pos_counter.sv
module qep_pos_counter
  import qep_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              enc_a,
  input  logic              enc_b,
  output logic              irq
);
  logic [1:0]       ab_sync;
  logic             pulse, up, ovf_evt, unf_evt, pos_wr, both_edges, cnt_en;
  logic [CNT_W-1:0] pos, max_pos;
  src_mode_e        mode;

  qep_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({enc_a, enc_b}), .sync_out(ab_sync)
  );

  qep_pulse_gen u_pulse (
    .clk(clk), .rst_n(rst_n), .a_in(ab_sync[1]), .b_in(ab_sync[0]),
    .mode(mode), .both_edges(both_edges), .pulse(pulse), .up(up)
  );

  qep_pos_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pulse(pulse), .up(up),
    .pos_wr(pos_wr), .pos_wdata(reg_wdata), .max_pos(max_pos),
    .pos(pos), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  qep_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pos(pos), .ovf_evt(ovf_evt), .unf_evt(unf_evt), .max_pos(max_pos),
    .pos_wr(pos_wr), .mode(mode), .both_edges(both_edges),
    .cnt_en(cnt_en), .irq(irq)
  );
endmodule

// File: tb/qep_pos_counter_tb.sv
module qep_pos_counter_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        irq;
  int          n_checks = 0, n_errors = 0;
  int          gray_idx = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qep_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    settle();
  endtask

  // Gray order {A,B}: 00,01,11,10
  task automatic gray_step(input bit fwd);
    gray_idx = fwd ? (gray_idx + 1) % 4 : (gray_idx + 3) % 4;
    case (gray_idx)
      0: set_ab(1'b0, 1'b0);
      1: set_ab(1'b0, 1'b1);
      2: set_ab(1'b1, 1'b1);
      default: set_ab(1'b1, 1'b0);
    endcase
  endtask

  task automatic a_pulse(input logic b);
    set_ab(1'b1, b);
    set_ab(1'b0, b);
  endtask

  task automatic setup(input logic [1:0] src, input logic rate, input logic [31:0] p);
    wr(8'h12, 32'd0);
    set_ab(1'b0, 1'b0);
    gray_idx = 0;
    wr(8'h10, {29'd0, rate, src});
    wr(8'h00, p);
    wr(8'h12, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); check("R1 position", d, 32'd0);
    rd(8'h04, d); check("R1 maximum", d, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R1 decode", d, 32'd0);
    rd(8'h12, d); check("R1 control", d, 32'd0);
    rd(8'h16, d); check("R1 flags", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h04, 32'd1000);
    rd(8'h04, d); check("R11 maximum readback", d, 32'd1000);
    wr(8'h10, 32'h0000_0006);
    rd(8'h10, d); check("R11 decode readback", d, 32'h6);
    wr(8'h14, 32'h0000_0060);
    rd(8'h14, d); check("R11 enable readback", d, 32'h60);
    rd(8'h18, d); check("R11 clear reads zero", d, 32'd0);
    wr(8'h14, 32'd0);
  endtask

  task automatic t_quad();
    logic [31:0] d;
    setup(2'd0, 1'b0, 32'd100);
    for (int i = 0; i < 8; i++) gray_step(1'b1);
    rd(8'h00, d); check("R2 quad forward x4", d, 32'd108);
    for (int i = 0; i < 3; i++) gray_step(1'b0);
    rd(8'h00, d); check("R2 quad reverse", d, 32'd105);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    setup(2'd0, 1'b0, 32'd200);
    set_ab(1'b1, 1'b1);
    rd(8'h00, d); check("R3 illegal 00->11", d, 32'd200);
    set_ab(1'b0, 1'b0);
    rd(8'h00, d); check("R3 illegal 11->00", d, 32'd200);
  endtask

  task automatic t_pdir();
    logic [31:0] d;
    setup(2'd1, 1'b0, 32'd50);
    for (int i = 0; i < 3; i++) a_pulse(1'b1);
    rd(8'h00, d); check("R4 B high counts up", d, 32'd53);
    for (int i = 0; i < 2; i++) a_pulse(1'b0);
    rd(8'h00, d); check("R4 B low counts down", d, 32'd51);
    set_ab(1'b0, 1'b1);
    set_ab(1'b0, 1'b0);
    rd(8'h00, d); check("R4 B alone no count", d, 32'd51);
  endtask

  task automatic t_single_dir();
    logic [31:0] d;
    setup(2'd2, 1'b0, 32'd10);
    a_pulse(1'b1);
    a_pulse(1'b0);
    rd(8'h00, d); check("R5 up rising only, B ignored", d, 32'd12);
    setup(2'd2, 1'b1, 32'd10);
    a_pulse(1'b0);
    a_pulse(1'b1);
    rd(8'h00, d); check("R5 up both edges", d, 32'd14);
    setup(2'd3, 1'b0, 32'd10);
    a_pulse(1'b1);
    rd(8'h00, d); check("R5 down rising only", d, 32'd9);
    setup(2'd3, 1'b1, 32'd10);
    a_pulse(1'b0);
    rd(8'h00, d); check("R5 down both edges", d, 32'd8);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    setup(2'd0, 1'b0, 32'd300);
    wr(8'h12, 32'd0);
    for (int i = 0; i < 4; i++) gray_step(1'b1);
    rd(8'h00, d); check("R6 disabled holds", d, 32'd300);
  endtask

  task automatic t_write_limit();
    logic [31:0] d;
    wr(8'h12, 32'd0);
    wr(8'h04, 32'd50);
    wr(8'h00, 32'd50);
    rd(8'h00, d); check("R7 write equal to max", d, 32'd50);
    wr(8'h00, 32'd51);
    rd(8'h00, d); check("R7 write above max ignored", d, 32'd50);
  endtask

  task automatic t_wrap_irq();
    logic [31:0] d;
    wr(8'h04, 32'd10);
    wr(8'h14, 32'h60);
    wr(8'h18, 32'h61);
    setup(2'd2, 1'b0, 32'd9);
    a_pulse(1'b0);
    a_pulse(1'b0);
    rd(8'h00, d); check("R8 overflow wraps to 0", d, 32'd0);
    rd(8'h16, d); check("R8 R9 overflow and global flags", d, 32'h41);
    check("R9 irq on enabled overflow", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h41);
    rd(8'h16, d); check("R10 clear overflow and global", d, 32'd0);
    check("R10 irq low after clear", {31'd0, irq}, 32'd0);
    setup(2'd3, 1'b0, 32'd0);
    a_pulse(1'b0);
    rd(8'h00, d); check("R8 underflow wraps to max", d, 32'd10);
    rd(8'h16, d); check("R8 underflow flag", d, 32'h21);
    wr(8'h18, 32'h20);
    rd(8'h16, d); check("R10 partial clear keeps global", d, 32'h01);
    check("R10 irq stays with global", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h01);
    check("R10 irq low after global clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    wr(8'h14, 32'h00);
    setup(2'd2, 1'b0, 32'd10);
    a_pulse(1'b0);
    rd(8'h16, d); check("R9 masked overflow sets own flag only", d, 32'h40);
    check("R9 masked overflow no irq", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_quad();
    t_illegal();
    t_pdir();
    t_single_dir();
    t_enable();
    t_write_limit();
    t_wrap_irq();
    t_masked();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule